// File: doc/BRIEF.md
# Banked Accumulator Shift Unit

This block holds the accumulator of a multiply-accumulate engine in two switchable register banks. Each bank is a 48-bit accumulator stored as three 16-bit words, plus a 16-bit rounding pair that sits beside it. A bank-select register decides which bank the register bus sees. A shift-control register lets software move the selected accumulator one bit right or one bit left. The right shift is arithmetic and the left shift is logical. The bit that leaves the accumulator is kept in a carry flag, and the flag stays set until software clears it.

Software reaches every register through a plain synchronous bus with an address, a write enable, write data and combinational read data. Fixed-point code uses the shift commands to rescale the accumulator cheaply. Bank switching lets one context be parked while another is in use, and neither context disturbs the other.

Top module: `acc_shift_bank`

## Requirements
- R1: After reset, every accumulator word, both rounding words, the carry flag and the bank select read as 0.
- R2: Writing the shift-control register with bit 1 set and bit 0 clear shifts the selected accumulator right by one on the clock edge after the write. Bit 47 keeps its value, each word's bit 0 moves into bit 15 of the word below it, and the old bit 0 goes to the carry flag.
- R3: Writing the shift-control register with bit 0 set and bit 1 clear shifts the selected accumulator left by one on the clock edge after the write. A 0 enters bit 0, each word's bit 15 moves into bit 0 of the word above it, and the old bit 47 goes to the carry flag.
- R4: The shift-control register reads back with the carry in bit 7 and 0 in bits 6:0, so the command bits always read 0. The bank-select register reads back with the select in bit 0 and 0 in bits 15:1.
- R5: Writing shift control with bit 7 = 0 clears the carry flag. Writing it with bit 7 = 1 leaves the carry flag as it was.
- R6: A write that sets both bit 1 and bit 0 performs no shift and leaves the carry flag unchanged, whatever bit 7 holds.
- R7: A shift never changes the rounding words.
- R8: Accumulator and rounding reads and writes reach only the bank picked by the select bit. The other bank keeps its contents through shifts and writes.
- R9: One command write produces exactly one shift. The accumulator then holds its value until the next write.
- R10: Register map: address 0 is the lower accumulator word (bits 15:0), address 1 the middle word, address 2 the upper word (bits 47:32), addresses 3 and 4 the lower and upper rounding words, address 5 shift control, address 6 bank select. Address 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, combinational |

## Verification
Read data follows the address with no register in the path. A write is visible at the first falling edge after the edge that takes it. A shift command lands one edge later, so its result and its carry are due at the second rising edge after the command was presented. The bench presents writes on falling edges and returns from the write task at the falling edge just after the capturing edge. It then samples on the following falling edge, which falls after the shift edge. For the exactly-once and no-effect rules, the bench reads again several idle cycles later and compares against the same expected value.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
   localparam int CTRL_W    = 8;
   localparam int CARRY_BIT = 7;
   localparam int RSH_BIT   = 1;
   localparam int LSH_BIT   = 0;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_RIGHT = 2'd1,
      OP_LEFT  = 2'd2
   } shift_op_e;
endpackage

// File: rtl/acc_shift_core.sv
module acc_shift_core
   import acc_shift_pkg::*;
#(
   parameter int ACC_W       = 48,
   parameter bit ARITH_RIGHT = 1'b1
) (
   input  logic [ACC_W-1:0] acc_in,
   input  shift_op_e        op,
   output logic [ACC_W-1:0] acc_out,
   output logic             bit_out
);
   initial begin
      assert (ACC_W >= 2) else $error("acc_shift_core: ACC_W must be at least 2");
   end

   logic fill_msb;

   generate
      if (ARITH_RIGHT) begin : g_arith
         assign fill_msb = acc_in[ACC_W-1];
      end else begin : g_logical
         assign fill_msb = 1'b0;
      end
   endgenerate

   always_comb begin
      acc_out = acc_in;
      bit_out = 1'b0;
      unique case (op)
         OP_RIGHT: begin
            acc_out = {fill_msb, acc_in[ACC_W-1:1]};
            bit_out = acc_in[0];
         end
         OP_LEFT: begin
            acc_out = {acc_in[ACC_W-2:0], 1'b0};
            bit_out = acc_in[ACC_W-1];
         end
         default: begin
            acc_out = acc_in;
            bit_out = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/acc_bank_store.sv
module acc_bank_store #(
   parameter int WORD_W    = 16,
   parameter int NUM_WORDS = 3,
   parameter int RND_WORDS = 2,
   localparam int ACC_W    = WORD_W * NUM_WORDS,
   localparam int RND_W    = WORD_W * RND_WORDS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WORDS-1:0] acc_we,
   input  logic [RND_WORDS-1:0] rnd_we,
   input  logic [WORD_W-1:0]    wdata,
   input  logic                 shift_en,
   input  logic [ACC_W-1:0]     shift_val,
   output logic [ACC_W-1:0]     acc_q,
   output logic [RND_W-1:0]     rnd_q
);
   initial begin
      assert (NUM_WORDS >= 1) else $error("acc_bank_store: NUM_WORDS must be at least 1");
      assert (RND_WORDS >= 1) else $error("acc_bank_store: RND_WORDS must be at least 1");
   end

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_acc
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q <= '0;
            else if (acc_we[w])
               word_q <= wdata;
            else if (shift_en)
               word_q <= shift_val[w*WORD_W +: WORD_W];
         end
         assign acc_q[w*WORD_W +: WORD_W] = word_q;
      end

      for (genvar r = 0; r < RND_WORDS; r++) begin : g_rnd
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q <= '0;
            else if (rnd_we[r])
               word_q <= wdata;
         end
         assign rnd_q[r*WORD_W +: WORD_W] = word_q;
      end
   endgenerate

   AST_ACC_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_we == '0 && !shift_en) |=> $stable(acc_q)) else $error("accumulator moved without write or shift"); // R8
   AST_RND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rnd_we == '0) |=> $stable(rnd_q)) else $error("rounding words changed without write"); // R7
   AST_SHIFT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && acc_we == '0) |=> acc_q == $past(shift_val)) else $error("shift result not stored"); // R9
endmodule

// File: rtl/acc_shift_ctrl.sv
module acc_shift_ctrl
   import acc_shift_pkg::*;
#(
   parameter int SEL_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic              sel_we,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              core_bit,
   output shift_op_e         op,
   output logic              carry,
   output logic [SEL_W-1:0]  bank_sel
);
   initial begin
      assert (SEL_W >= 1 && SEL_W < CTRL_W) else $error("acc_shift_ctrl: SEL_W out of range");
   end

   logic want_r, want_l, both_cmd;
   assign want_r   = wdata[RSH_BIT];
   assign want_l   = wdata[LSH_BIT];
   assign both_cmd = want_r & want_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         op <= OP_HOLD;
      else if (ctrl_we && want_r && !want_l)
         op <= OP_RIGHT;
      else if (ctrl_we && want_l && !want_r)
         op <= OP_LEFT;
      else
         op <= OP_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         carry <= 1'b0;
      else if (op != OP_HOLD)
         carry <= core_bit;
      else if (ctrl_we && !both_cmd && !wdata[CARRY_BIT])
         carry <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bank_sel <= '0;
      else if (sel_we)
         bank_sel <= wdata[SEL_W-1:0];
   end

   AST_OP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_HOLD && !ctrl_we) |=> op == OP_HOLD) else $error("shift repeated"); // R9
   AST_BOTH_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && both_cmd) |=> op == OP_HOLD) else $error("both commands shifted"); // R6
   AST_BOTH_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && both_cmd && op == OP_HOLD) |=> $stable(carry)) else $error("both commands touched carry"); // R6
   AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_HOLD && !(ctrl_we && !wdata[CARRY_BIT])) |=> $stable(carry)) else $error("carry changed"); // R5
   AST_CARRY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_HOLD) |=> carry == $past(core_bit)) else $error("shifted-out bit lost"); // R2
endmodule

// File: rtl/acc_reg_decode.sv
module acc_reg_decode
   import acc_shift_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int NUM_WORDS = 3,
   parameter int RND_WORDS = 2,
   parameter int ADDR_W    = 3,
   parameter int SEL_W     = 1,
   localparam int ACC_W    = WORD_W * NUM_WORDS,
   localparam int RND_W    = WORD_W * RND_WORDS,
   localparam int A_CTRL   = NUM_WORDS + RND_WORDS,
   localparam int A_SEL    = A_CTRL + 1
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 we,
   input  logic [ACC_W-1:0]     acc_act,
   input  logic [RND_W-1:0]     rnd_act,
   input  logic                 carry,
   input  logic [SEL_W-1:0]     bank_sel,
   output logic [NUM_WORDS-1:0] acc_we,
   output logic [RND_WORDS-1:0] rnd_we,
   output logic                 ctrl_we,
   output logic                 sel_we,
   output logic [WORD_W-1:0]    rdata
);
   initial begin
      assert (A_SEL < (1 << ADDR_W)) else $error("acc_reg_decode: ADDR_W too narrow for map");
      assert (WORD_W >= CTRL_W) else $error("acc_reg_decode: WORD_W narrower than control registers");
   end

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_acc_dec
         assign acc_we[w] = we && (addr == ADDR_W'(w));
      end
      for (genvar r = 0; r < RND_WORDS; r++) begin : g_rnd_dec
         assign rnd_we[r] = we && (addr == ADDR_W'(NUM_WORDS + r));
      end
   endgenerate

   assign ctrl_we = we && (addr == ADDR_W'(A_CTRL));
   assign sel_we  = we && (addr == ADDR_W'(A_SEL));

   always_comb begin
      rdata = '0;
      for (int w = 0; w < NUM_WORDS; w++)
         if (addr == ADDR_W'(w))
            rdata = acc_act[w*WORD_W +: WORD_W];
      for (int r = 0; r < RND_WORDS; r++)
         if (addr == ADDR_W'(NUM_WORDS + r))
            rdata = rnd_act[r*WORD_W +: WORD_W];
      if (addr == ADDR_W'(A_CTRL))
         rdata[CARRY_BIT] = carry;
      if (addr == ADDR_W'(A_SEL))
         rdata[SEL_W-1:0] = bank_sel;
   end
endmodule

// File: rtl/acc_shift_bank.sv
module acc_shift_bank
   import acc_shift_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int NUM_WORDS   = 3,
   parameter int RND_WORDS   = 2,
   parameter int NUM_BANKS   = 2,
   parameter int ADDR_W      = 3,
   parameter bit ARITH_RIGHT = 1'b1,
   localparam int ACC_W      = WORD_W * NUM_WORDS,
   localparam int RND_W      = WORD_W * RND_WORDS,
   localparam int SEL_W      = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata
);
   initial begin
      assert (NUM_BANKS >= 2) else $error("acc_shift_bank: at least two banks needed");
      assert ((1 << SEL_W) == NUM_BANKS) else $error("acc_shift_bank: NUM_BANKS must be a power of two");
   end

   logic [NUM_WORDS-1:0] acc_we;
   logic [RND_WORDS-1:0] rnd_we;
   logic                 ctrl_we, sel_we;
   shift_op_e            op;
   logic                 carry, core_bit;
   logic [SEL_W-1:0]     bank_sel;
   logic [ACC_W-1:0]     acc_act, shift_val;
   logic [RND_W-1:0]     rnd_act;
   logic [ACC_W-1:0]     bank_acc [NUM_BANKS];
   logic [RND_W-1:0]     bank_rnd [NUM_BANKS];

   acc_reg_decode #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .RND_WORDS(RND_WORDS),
      .ADDR_W(ADDR_W), .SEL_W(SEL_W)
   ) u_decode (
      .addr(bus_addr), .we(bus_we), .acc_act(acc_act), .rnd_act(rnd_act),
      .carry(carry), .bank_sel(bank_sel), .acc_we(acc_we), .rnd_we(rnd_we),
      .ctrl_we(ctrl_we), .sel_we(sel_we), .rdata(bus_rdata)
   );

   acc_shift_ctrl #(.SEL_W(SEL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .sel_we(sel_we),
      .wdata(bus_wdata[CTRL_W-1:0]), .core_bit(core_bit),
      .op(op), .carry(carry), .bank_sel(bank_sel)
   );

   acc_shift_core #(.ACC_W(ACC_W), .ARITH_RIGHT(ARITH_RIGHT)) u_core (
      .acc_in(acc_act), .op(op), .acc_out(shift_val), .bit_out(core_bit)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic here;
         assign here = (bank_sel == SEL_W'(b));
         acc_bank_store #(
            .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .RND_WORDS(RND_WORDS)
         ) u_store (
            .clk(clk), .rst_n(rst_n),
            .acc_we(acc_we & {NUM_WORDS{here}}),
            .rnd_we(rnd_we & {RND_WORDS{here}}),
            .wdata(bus_wdata),
            .shift_en(here && op != OP_HOLD),
            .shift_val(shift_val),
            .acc_q(bank_acc[b]),
            .rnd_q(bank_rnd[b])
         );
      end
   endgenerate

   assign acc_act = bank_acc[bank_sel];
   assign rnd_act = bank_rnd[bank_sel];

   AST_RIGHT_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RIGHT && acc_we == '0 && !sel_we) |=> acc_act[ACC_W-1] == $past(acc_act[ACC_W-1])) else $error("sign bit lost on right shift"); // R2
   AST_LEFT_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LEFT && acc_we == '0 && !sel_we) |=> acc_act[0] == 1'b0) else $error("left shift did not insert zero"); // R3
   AST_LEFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LEFT) |=> carry == $past(acc_act[ACC_W-1])) else $error("left carry wrong"); // R3
endmodule

// File: tb/acc_shift_bank_tb.sv
module acc_shift_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   acc_shift_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   localparam logic [2:0] A_LO = 3'd0, A_MID = 3'd1, A_HI = 3'd2, A_RL = 3'd3,
                          A_RH = 3'd4, A_CTL = 3'd5, A_SEL = 3'd6, A_NONE = 3'd7;

   function automatic logic [47:0] sra48(input logic [47:0] v);
      return {v[47], v[47:1]};
   endfunction
   function automatic logic [47:0] sll48(input logic [47:0] v);
      return {v[46:0], 1'b0};
   endfunction

   task automatic check(input string req, input string what, input logic [47:0] got, input logic [47:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic set_acc(input logic [47:0] v);
      wr(A_LO, v[15:0]); wr(A_MID, v[31:16]); wr(A_HI, v[47:32]);
   endtask

   task automatic get_acc(output logic [47:0] v);
      logic [15:0] w;
      rd(A_LO, w);  v[15:0]  = w;
      rd(A_MID, w); v[31:16] = w;
      rd(A_HI, w);  v[47:32] = w;
   endtask

   task automatic t_reset;
      logic [47:0] v; logic [15:0] d;
      get_acc(v);     check("R1", "accumulator after reset", v, 48'h0);
      rd(A_CTL, d);   check("R1", "shift control after reset", {32'h0, d}, 48'h0);
      rd(A_SEL, d);   check("R1", "bank select after reset", {32'h0, d}, 48'h0);
      rd(A_RH, d);    check("R1", "rounding after reset", {32'h0, d}, 48'h0);
   endtask

   task automatic t_right;
      logic [47:0] v; logic [15:0] d;
      set_acc(48'h8000_0000_0001);
      wr(A_CTL, 16'h0002);
      get_acc(v);   check("R2", "right shift sign fill", v, sra48(48'h8000_0000_0001));
      rd(A_CTL, d); check("R2", "right carry gets bit 0 (R4 cmd reads 0)", {32'h0, d}, 48'h80);
      set_acc(48'h0001_0001_0000);
      wr(A_CTL, 16'h0002);
      get_acc(v);   check("R2", "right shift across word boundary", v, 48'h0000_8000_8000);
      rd(A_CTL, d); check("R2", "right carry takes new bit 0", {32'h0, d}, 48'h0);
   endtask

   task automatic t_left;
      logic [47:0] v; logic [15:0] d;
      set_acc(48'h8000_8000_8001);
      wr(A_CTL, 16'h0001);
      get_acc(v);   check("R3", "left shift across words", v, sll48(48'h8000_8000_8001));
      rd(A_CTL, d); check("R3", "left carry gets bit 47", {32'h0, d}, 48'h80);
      check("R4", "command bits read 0", {46'h0, d[1:0]}, 48'h0);
   endtask

   task automatic t_once;
      logic [47:0] v;
      set_acc(48'h0000_0000_0F00);
      wr(A_CTL, 16'h0002);
      repeat (5) @(negedge clk);
      get_acc(v);   check("R9", "single shift per command", v, 48'h0000_0000_0780);
   endtask

   task automatic t_carry;
      logic [15:0] d;
      set_acc(48'h8000_0000_0000);
      wr(A_CTL, 16'h0001);
      wr(A_CTL, 16'h0080);
      rd(A_CTL, d); check("R5", "writing 1 to carry keeps it", {32'h0, d}, 48'h80);
      wr(A_CTL, 16'h007C);
      rd(A_CTL, d); check("R5", "writing 0 clears carry, reserved read 0 (R4)", {32'h0, d}, 48'h0);
   endtask

   task automatic t_both;
      logic [47:0] v; logic [15:0] d;
      set_acc(48'h0000_0000_0003);
      wr(A_CTL, 16'h0002);
      wr(A_CTL, 16'h0003);
      repeat (2) @(negedge clk);
      get_acc(v);   check("R6", "both commands leave accumulator", v, 48'h0000_0000_0001);
      rd(A_CTL, d); check("R6", "both commands keep carry", {32'h0, d}, 48'h80);
   endtask

   task automatic t_round;
      logic [15:0] d;
      wr(A_RL, 16'hA5C3); wr(A_RH, 16'h1234);
      wr(A_CTL, 16'h0001);
      wr(A_CTL, 16'h0002);
      rd(A_RL, d); check("R7", "rounding low after shifts", {32'h0, d}, 48'hA5C3);
      rd(A_RH, d); check("R7", "rounding high after shifts", {32'h0, d}, 48'h1234);
   endtask

   task automatic t_bank;
      logic [47:0] v; logic [15:0] d;
      set_acc(48'h1111_2222_3333);
      wr(A_RL, 16'h00AA);
      wr(A_SEL, 16'hFFFF);
      rd(A_SEL, d); check("R4", "select reads only bit 0", {32'h0, d}, 48'h1);
      get_acc(v);   check("R8", "bank 1 starts clear", v, 48'h0);
      set_acc(48'h4000_0000_0001);
      wr(A_RL, 16'h0055);
      wr(A_CTL, 16'h0001);
      get_acc(v);   check("R8", "shift acts on bank 1", v, 48'h8000_0000_0002);
      wr(A_SEL, 16'h0000);
      get_acc(v);   check("R8", "bank 0 untouched", v, 48'h1111_2222_3333);
      rd(A_RL, d);  check("R8", "bank 0 rounding kept", {32'h0, d}, 48'h00AA);
      wr(A_SEL, 16'h0001);
      rd(A_RL, d);  check("R8", "bank 1 rounding kept", {32'h0, d}, 48'h0055);
      wr(A_SEL, 16'h0000);
   endtask

   task automatic t_map;
      logic [15:0] d;
      rd(A_NONE, d); check("R10", "unused address reads 0", {32'h0, d}, 48'h0);
      wr(A_HI, 16'hBEEF);
      rd(A_HI, d);   check("R10", "upper word at address 2", {32'h0, d}, 48'hBEEF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_right();
      t_left();
      t_once();
      t_carry();
      t_both();
      t_round();
      t_bank();
      t_map();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements): actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule